// File: doc/BRIEF.md
# Byte-Serial Palette RAM Port

This block holds a 256-entry colour palette of 16-bit words and gives a processor byte-wide access to it. The processor sets an 8-bit entry pointer and then moves bytes in or out through one write strobe and one read strobe. A low/high phase bit decides which half of the word each byte access touches. Reads and writes share this phase bit. The pointer moves on by one after each completed word, so a whole palette can be loaded or dumped as a stream of bytes once the starting entry is set.

A second port is for the pixel pipeline. It takes an entry index each cycle and returns that entry one cycle later as three 8-bit channels. Each channel is widened from its 5-bit field by repeating the channel's top bits into the new low bits. This port has no effect on the pointer or the phase bit.

The phase bit is a two-state machine, `PH_LOW` and `PH_HIGH`. The transition `LOW_TO_HIGH` is taken on a byte access in `PH_LOW`. The transition `HIGH_TO_LOW_STEP` is taken on a byte access in `PH_HIGH` and also advances the pointer. The transition `POINTER_LOAD` is taken on any pointer write and leads to `PH_LOW` from either state. When no strobe is active the state holds.

Top module: `pal_ram_port`

## Requirements
- R1: After reset the phase is low and the pointer is 0, `cpu_rdata` is 0x00, and the three colour outputs are 0x00.
- R2: A cycle with `cpu_ptr_we` loads the pointer from `cpu_wdata` and forces the phase low. In that cycle any data write or read strobe is ignored: no entry changes and `cpu_rdata` holds its value.
- R3: A data write in the low phase replaces bits 7:0 of the entry the pointer selects, keeps bits 15:8, and moves the phase to high. The pointer does not change.
- R4: A data write in the high phase replaces bits 15:8, keeps bits 7:0, and returns the phase to low. The pointer then increases by one, and 0xFF is followed by 0x00.
- R5: A data read presents bits 7:0 of the selected entry on `cpu_rdata` in the low phase and bits 15:8 in the high phase. The byte appears from the cycle after the strobe and holds until the next read that takes effect. The read moves the phase and the pointer exactly as a write does. For example, entry 0x10 holding 0x1234 reads as 0x34 and then 0x12, and the pointer ends at 0x11.
- R6: When the data write and data read strobes are both high, with no pointer write, the write is performed and the read is ignored: `cpu_rdata` keeps its value.
- R7: One phase bit serves both directions. A read in the low phase followed by a write sends the written byte to bits 15:8.
- R8: The renderer port returns the entry selected by `rnd_index`, sampled at a clock edge, on the colour outputs after that edge. Red comes from bits 4:0, green from bits 9:5 and blue from bits 14:10, and bit 15 has no effect. Each 5-bit value v becomes (v<<3)|(v>>2). For example, 0b10101, 0b01010 and 0b11011 give 0xAD, 0x52 and 0xDE.
- R9: Renderer reads never change the pointer or the phase. When no processor strobe is active, both hold.
- R10: A renderer read in the same cycle as a processor write to the same entry returns the contents from before the write. The new value shows from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ptr_we | input | 1 | Load the entry pointer from `cpu_wdata` |
| cpu_data_we | input | 1 | Byte write to the selected entry |
| cpu_data_re | input | 1 | Byte read from the selected entry |
| cpu_wdata | input | 8 | Byte value for pointer or data writes |
| cpu_rdata | output | 8 | Last byte read, registered |
| rnd_index | input | 8 | Renderer entry index |
| rnd_red | output | 8 | Widened red channel |
| rnd_green | output | 8 | Widened green channel |
| rnd_blue | output | 8 | Widened blue channel |

## Verification
The bound checker checks every cycle that the phase and pointer follow the state transitions. A pointer load gives the loaded value and the low phase. A low-phase access leaves the pointer unchanged and moves to high. A high-phase access moves to low and adds one to the pointer. With no strobe, both hold. It also checks that a read that loses to a write leaves `cpu_rdata` unchanged. The stored byte contents, the byte-lane merging, the wrap of the pointer, the channel widening and the read-before-write behaviour of the renderer port are only shown by the bench. It compares reads against its own reference model of the palette, using directed sequences and a long random mix of strobes.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/pal_phase_fsm.sv
module pal_phase_fsm
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic             data_we,
    input  logic             data_re,
    input  logic [IDX_W-1:0] ptr_val,
    output phase_e           phase_q,
    output logic [IDX_W-1:0] ptr_q,
    output logic             wr_lo,
    output logic             wr_hi,
    output logic             rd_lo,
    output logic             rd_hi
);
    phase_e           phase_d;
    logic [IDX_W-1:0] ptr_d;
    logic             access;

    assign access = data_we | data_re;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
            ptr_q   <= '0;
        end else begin
            phase_q <= phase_d;
            ptr_q   <= ptr_d;
        end
    end

    // transitions and strobe decoding
    always_comb begin
        phase_d = phase_q;
        ptr_d   = ptr_q;
        wr_lo   = 1'b0;
        wr_hi   = 1'b0;
        rd_lo   = 1'b0;
        rd_hi   = 1'b0;
        if (ptr_we) begin
            // POINTER_LOAD
            phase_d = PH_LOW;
            ptr_d   = ptr_val;
        end else if (access) begin
            unique case (phase_q)
                PH_LOW: begin
                    // LOW_TO_HIGH
                    phase_d = PH_HIGH;
                    wr_lo   = data_we;
                    rd_lo   = data_re & ~data_we;
                end
                PH_HIGH: begin
                    // HIGH_TO_LOW_STEP
                    phase_d = PH_LOW;
                    ptr_d   = ptr_q + 1'b1;
                    wr_hi   = data_we;
                    rd_hi   = data_re & ~data_we;
                end
            endcase
        end
    end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int IDX_W  = 8,
    parameter int BYTE_W = 8,
    parameter int COL_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte_q,
    input  logic [IDX_W-1:0]  rnd_idx,
    output logic [COL_W-1:0]  rnd_word_q
);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_lo) mem[cpu_idx][BYTE_W-1:0]      <= wbyte;
        if (wr_hi) mem[cpu_idx][WORD_W-1:BYTE_W] <= wbyte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte_q    <= '0;
            rnd_word_q <= '0;
        end else begin
            if (rd_lo)      rbyte_q <= mem[cpu_idx][BYTE_W-1:0];
            else if (rd_hi) rbyte_q <= mem[cpu_idx][WORD_W-1:BYTE_W];
            rnd_word_q <= mem[rnd_idx][COL_W-1:0];
        end
    end
endmodule

// File: rtl/pal_widen.sv
module pal_widen #(
    parameter int CH_W  = 5,
    parameter int OUT_W = 8
) (
    input  logic [CH_W-1:0]  ch_in,
    output logic [OUT_W-1:0] ch_out
);
    localparam int FILL = OUT_W - CH_W;

    generate
        if (FILL == 0) begin : g_same
            assign ch_out = ch_in;
        end else begin : g_fill
            assign ch_out = {ch_in, ch_in[CH_W-1 -: FILL]};
        end
    endgenerate
endmodule

// File: rtl/pal_ram_port.sv
module pal_ram_port
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 5,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ptr_we,
    input  logic             cpu_data_we,
    input  logic             cpu_data_re,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic [IDX_W-1:0] rnd_index,
    output logic [OUT_W-1:0] rnd_red,
    output logic [OUT_W-1:0] rnd_green,
    output logic [OUT_W-1:0] rnd_blue
);
    localparam int BYTE_W = 8;
    localparam int NCH    = 3;
    localparam int COL_W  = NCH * CH_W;

    phase_e             phase_q;
    logic [IDX_W-1:0]   ptr_q;
    logic               wr_lo, wr_hi, rd_lo, rd_hi;
    logic [COL_W-1:0]   rnd_word_q;
    logic [OUT_W-1:0]   chan [NCH];

    pal_phase_fsm #(.IDX_W(IDX_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_we  (cpu_ptr_we),
        .data_we (cpu_data_we),
        .data_re (cpu_data_re),
        .ptr_val (cpu_wdata[IDX_W-1:0]),
        .phase_q (phase_q),
        .ptr_q   (ptr_q),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi)
    );

    pal_store #(.IDX_W(IDX_W), .BYTE_W(BYTE_W), .COL_W(COL_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_idx    (ptr_q),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .wbyte      (cpu_wdata),
        .rbyte_q    (cpu_rdata),
        .rnd_idx    (rnd_index),
        .rnd_word_q (rnd_word_q)
    );

    // channel 0 red, 1 green, 2 blue
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pal_widen #(.CH_W(CH_W), .OUT_W(OUT_W)) widen_i (
            .ch_in  (rnd_word_q[c*CH_W +: CH_W]),
            .ch_out (chan[c])
        );
    end

    assign rnd_red   = chan[0];
    assign rnd_green = chan[1];
    assign rnd_blue  = chan[2];
endmodule

// File: rtl/pal_ram_port_chk.sv
module pal_ram_port_chk
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ptr_we,
    input logic             cpu_data_we,
    input logic             cpu_data_re,
    input logic [7:0]       cpu_wdata,
    input logic [7:0]       cpu_rdata,
    input phase_e           phase_q,
    input logic [IDX_W-1:0] ptr_q
);
    logic acc;
    assign acc = !cpu_ptr_we && (cpu_data_we || cpu_data_re);

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ptr_we |=> (phase_q == PH_LOW && ptr_q == $past(cpu_wdata[IDX_W-1:0])));

    assert_low_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && phase_q == PH_LOW) |=> (phase_q == PH_HIGH && $stable(ptr_q)));

    assert_high_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && phase_q == PH_HIGH) |=>
            (phase_q == PH_LOW && ptr_q == IDX_W'($past(ptr_q) + 1'b1)));

    assert_read_loses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ptr_we && cpu_data_we && cpu_data_re) |=> $stable(cpu_rdata));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ptr_we && !cpu_data_we && !cpu_data_re) |=> ($stable(ptr_q) && $stable(phase_q)));
endmodule

bind pal_ram_port pal_ram_port_chk #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ptr_we  (cpu_ptr_we),
    .cpu_data_we (cpu_data_we),
    .cpu_data_re (cpu_data_re),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .phase_q     (phase_q),
    .ptr_q       (ptr_q)
);

// File: tb/pal_ram_port_tb_top.sv
module pal_ram_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_ptr_we = 1'b0, cpu_data_we = 1'b0, cpu_data_re = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata, rnd_index = '0;
    logic [7:0] rnd_red, rnd_green, rnd_blue;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model
    logic [15:0] m_mem [256];
    logic [7:0]  m_ptr = '0;
    bit          m_hi = 1'b0;
    logic [7:0]  m_rd = '0;

    always #4 clk = ~clk;

    pal_ram_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_ptr_we(cpu_ptr_we), .cpu_data_we(cpu_data_we), .cpu_data_re(cpu_data_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rnd_index(rnd_index),
        .rnd_red(rnd_red), .rnd_green(rnd_green), .rnd_blue(rnd_blue)
    );

    function automatic logic [7:0] widen(input logic [4:0] v);
        logic [7:0] w;
        w = {3'b000, v};
        return 8'((w << 3) | (w >> 2));
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [15:0] e);
        return {widen(e[4:0]), widen(e[9:5]), widen(e[14:10])};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic aw, input logic dw, input logic dr,
                       input logic [7:0] wd, input logic [7:0] idx,
                       input bit ck_rd, input bit ck_rnd, input string req);
        logic [15:0] old_e;
        old_e = m_mem[idx];
        @(negedge clk);
        cpu_ptr_we = aw; cpu_data_we = dw; cpu_data_re = dr;
        cpu_wdata = wd; rnd_index = idx;
        @(posedge clk);
        #1;
        cpu_ptr_we = 1'b0; cpu_data_we = 1'b0; cpu_data_re = 1'b0;
        if (aw) begin
            m_ptr = wd; m_hi = 1'b0;
        end else if (dw || dr) begin
            if (dw) begin
                if (!m_hi) m_mem[m_ptr][7:0] = wd;
                else       m_mem[m_ptr][15:8] = wd;
            end else begin
                m_rd = m_hi ? m_mem[m_ptr][15:8] : m_mem[m_ptr][7:0];
            end
            if (m_hi) m_ptr = m_ptr + 8'd1;
            m_hi = !m_hi;
        end
        if (ck_rd)  chk(req, {24'd0, cpu_rdata}, {24'd0, m_rd});
        if (ck_rnd) chk(req, {8'd0, rnd_red, rnd_green, rnd_blue}, {8'd0, exp_rgb(old_e)});
    endtask

    task automatic idle_rnd(input logic [7:0] idx, input string req);
        cyc(1'b0, 1'b0, 1'b0, 8'h00, idx, 1'b1, 1'b1, req);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset outputs
        chk("R1 rdata", {24'd0, cpu_rdata}, 32'd0);
        chk("R1 rgb", {8'd0, rnd_red, rnd_green, rnd_blue}, 32'd0);
        // R1 pointer 0 and low phase after reset
        cyc(0, 1, 0, 8'h55, 8'h00, 0, 0, "R1");
        cyc(0, 1, 0, 8'hAA, 8'h00, 0, 0, "R1");
        cyc(1, 0, 0, 8'h00, 8'h00, 1, 0, "R2");
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R1 low byte at entry 0");
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R5 high byte");
        // fill the whole palette; pointer wraps to 0 (R4)
        cyc(1, 0, 0, 8'h00, 8'h00, 0, 0, "R2");
        for (int i = 0; i < 512; i++) cyc(0, 1, 0, 8'(i * 37 + 11), 8'h00, 0, 0, "R3");
        cyc(0, 1, 0, 8'h77, 8'h00, 0, 0, "R4 wrap");
        idle_rnd(8'h00, "R4 wrap to 0x00");
        idle_rnd(8'hFF, "R4 last entry");
        // R5 worked example
        cyc(1, 0, 0, 8'h10, 8'h00, 0, 0, "R2");
        cyc(0, 1, 0, 8'h34, 8'h00, 0, 0, "R3");
        cyc(0, 1, 0, 8'h12, 8'h00, 0, 0, "R4");
        cyc(1, 0, 0, 8'h10, 8'h00, 0, 0, "R2");
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R5 0x34");
        chk("R5 low", {24'd0, cpu_rdata}, 32'h34);
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R5 0x12");
        chk("R5 high", {24'd0, cpu_rdata}, 32'h12);
        cyc(0, 1, 0, 8'h9A, 8'h00, 0, 0, "R5");
        cyc(0, 1, 0, 8'hBC, 8'h00, 0, 0, "R5");
        idle_rnd(8'h11, "R5 pointer at 0x11");
        idle_rnd(8'h10, "R3 R4 byte merge");
        // R2 pointer write mid-word restarts at the low byte
        cyc(1, 0, 0, 8'h20, 8'h00, 0, 0, "R2");
        cyc(0, 1, 0, 8'h11, 8'h00, 0, 0, "R2");
        cyc(1, 0, 0, 8'h20, 8'h00, 0, 0, "R2");
        cyc(0, 1, 0, 8'h22, 8'h00, 0, 0, "R2");
        cyc(0, 1, 0, 8'h33, 8'h00, 0, 0, "R2");
        idle_rnd(8'h20, "R2 phase forced low");
        // R2 priority over data strobes
        cyc(1, 1, 1, 8'h40, 8'h40, 1, 1, "R2 strobes ignored");
        idle_rnd(8'h40, "R2 entry unchanged");
        cyc(0, 1, 0, 8'h01, 8'h00, 0, 0, "R2");
        cyc(0, 1, 0, 8'h02, 8'h00, 0, 0, "R2");
        idle_rnd(8'h40, "R2 pointer loaded");
        // R6 write beats read
        cyc(1, 0, 0, 8'h41, 8'h00, 0, 0, "R2");
        cyc(0, 1, 1, 8'hC3, 8'h41, 1, 1, "R6 rdata held");
        cyc(0, 1, 1, 8'h3C, 8'h41, 1, 1, "R6 rdata held");
        idle_rnd(8'h41, "R6 write performed");
        // R7 shared phase
        cyc(1, 0, 0, 8'h50, 8'h00, 0, 0, "R2");
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R7");
        cyc(0, 1, 0, 8'hEE, 8'h00, 0, 0, "R7");
        idle_rnd(8'h50, "R7 byte went high");
        // R8 colour example, bit 15 ignored
        cyc(1, 0, 0, 8'h60, 8'h00, 0, 0, "R2");
        cyc(0, 1, 0, 8'h55, 8'h00, 0, 0, "R8");
        cyc(0, 1, 0, 8'hED, 8'h00, 0, 0, "R8");
        cyc(0, 1, 0, 8'h55, 8'h00, 0, 0, "R8");
        // R10 same-cycle render of the entry being completed
        cyc(0, 1, 0, 8'h6D, 8'h61, 0, 1, "R10 old contents");
        idle_rnd(8'h60, "R8");
        chk("R8 colour example", {8'd0, rnd_red, rnd_green, rnd_blue}, 32'h00AD52DE);
        idle_rnd(8'h61, "R10 new contents");
        chk("R8 bit15 ignored", {8'd0, rnd_red, rnd_green, rnd_blue}, 32'h00AD52DE);
        // R9 renderer traffic leaves the phase alone
        cyc(1, 0, 0, 8'h70, 8'h00, 0, 0, "R2");
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R9");
        for (int i = 0; i < 6; i++) idle_rnd(8'(i * 41), "R9");
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R9 high byte after idle");
        cyc(0, 0, 1, 8'h00, 8'h00, 1, 0, "R9 pointer stepped once");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            cyc(r == 0, r >= 1 && r <= 5, r >= 4 && r <= 9,
                8'($urandom), 8'($urandom), 1, 1, "R5 R6 R8 random");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule